// File: doc/BRIEF.md
# Configuration Table Walker

This block applies a batch of register updates, prepared as a table in a local memory, to a descriptor RAM. A single-cycle start pulse hands it the word address of the table. The walker first reads a 64-bit header word and accepts it only if its upper half holds a fixed signature. The lower half of the header gives the number of update entries. The entries follow the header in consecutive table words. Each entry becomes one 32-bit write, at a 32-bit address, into the descriptor RAM.

Reads of entries are streamed, so the walker issues one table read per cycle and one descriptor write per cycle. It reports completion only after the last write has been presented on the write port. A later transfer trigger that waits for completion therefore sees every new value. A header without the signature causes no writes and is reported as an error. A start pulse that arrives during a walk has no effect.

States: IDLE (waiting), HEAD (header read issued), CHECK (header inspected, first entry read issued), STREAM (entries arriving and being written), DRAIN (last write on the port), FINISH (done pulse), FAULT (error pulse). Transitions: IDLE→HEAD on start; HEAD→CHECK always; CHECK→FAULT on bad signature, CHECK→FINISH on zero count, CHECK→STREAM otherwise; STREAM→DRAIN when the last entry is captured; DRAIN→FINISH; FINISH→IDLE; FAULT→IDLE.

Top module: `cfg_table_walker`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o, tbl_rd_en_o and desc_wr_en_o are all 0.
- R2: The header word holds the signature 0xDEADC0DE in bits 63:32 and the entry count in bits 31:0; it is read from table address base_i, which is sampled with start_i.
- R3: If bits 63:32 of the header differ from 0xDEADC0DE, no descriptor write occurs and err_o pulses for one cycle, three clock edges after the edge that sampled start_i; the block then returns to idle.
- R4: Entry k (k = 0 .. count-1) is read from table address base_i+1+k, modulo the table address range; its bits 63:32 become desc_wr_addr_o and its bits 31:0 become desc_wr_data_o.
- R5: Exactly count writes occur, in ascending entry order, so that when two entries target the same address, the later value remains in the descriptor RAM.
- R6: A count of zero produces no writes and a one-cycle done_o three edges after the start edge.
- R7: For a nonzero count N, done_o pulses for one cycle, N+4 edges after the start edge, in the cycle right after the last write; done_o never coincides with a write.
- R8: The table memory has one cycle of read latency. Table reads within a walk use consecutive ascending addresses. The N writes occupy N consecutive cycles, at most one write per cycle.
- R9: start_i is ignored while busy_o is 1: the running walk completes unchanged and no second walk follows.
- R10: busy_o is 1 from the cycle after the start edge through the done_o or err_o cycle, and 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| base_i | input | TADDR_W | Table word address of the header |
| tbl_rd_en_o | output | 1 | Table read enable |
| tbl_rd_addr_o | output | TADDR_W | Table read word address |
| tbl_rd_data_i | input | 64 | Table read data, valid one cycle after the enable |
| desc_wr_en_o | output | 1 | Descriptor RAM write enable |
| desc_wr_addr_o | output | 32 | Descriptor RAM write address |
| desc_wr_data_o | output | 32 | Descriptor RAM write value |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle bad-signature pulse |

## Verification
On every cycle, the assertions check that done_o and err_o are exclusive, that neither coincides with a write, and that a bad signature is followed by no write. They also check that table reads step by one, that all port activity stays inside the busy window, and that a start pulse during a walk does not end it. Only the bench scenarios can show the arithmetic results: the exact write contents and their order for each count and base, including wrap of the table address, the done and error latencies, and the final descriptor RAM value when entries hit the same address.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam logic [HALF_W-1:0] CTW_SIGNATURE = 32'hDEADC0DE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_CHECK,
        ST_STREAM,
        ST_DRAIN,
        ST_FINISH,
        ST_FAULT
    } ctw_state_e;
endpackage

// File: rtl/ctw_hdr_check.sv
module ctw_hdr_check
    import ctw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              sig_ok_o,
    output logic [HALF_W-1:0] count_o,
    output logic              count_zero_o
);
    always_comb begin
        sig_ok_o     = (word_i[WORD_W-1:HALF_W] == CTW_SIGNATURE);
        count_o      = word_i[HALF_W-1:0];
        count_zero_o = (word_i[HALF_W-1:0] == '0);
    end
endmodule

// File: rtl/ctw_rd_seq.sv
module ctw_rd_seq #(
    parameter int unsigned TADDR_W = 8,
    parameter int unsigned CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               issue_i,
    input  logic [TADDR_W-1:0] base_i,
    output logic [CNT_W-1:0]   issued_o,
    output logic [TADDR_W-1:0] entry_addr_o,
    output logic               pend_o
);
    logic [CNT_W-1:0] issued_q;
    logic             pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            pend_q <= issue_i;
            if (clear_i)
                issued_q <= '0;
            else if (issue_i)
                issued_q <= issued_q + CNT_W'(1);
        end
    end

    always_comb begin
        entry_addr_o = base_i + TADDR_W'(1) + TADDR_W'(issued_q);
        issued_o     = issued_q;
        pend_o       = pend_q;
    end
endmodule

// File: rtl/ctw_wr_stage.sv
module ctw_wr_stage
    import ctw_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] entry_i,
    output logic              wr_en_o,
    output logic [HALF_W-1:0] wr_addr_o,
    output logic [HALF_W-1:0] wr_data_o,
    output logic [CNT_W-1:0]  cap_cnt_o
);
    logic [CNT_W-1:0] cap_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            cap_cnt_q <= '0;
        end else begin
            wr_en_o <= cap_i;
            if (cap_i) begin
                wr_addr_o <= entry_i[WORD_W-1:HALF_W];
                wr_data_o <= entry_i[HALF_W-1:0];
            end
            if (clear_i)
                cap_cnt_q <= '0;
            else if (cap_i)
                cap_cnt_q <= cap_cnt_q + CNT_W'(1);
        end
    end

    assign cap_cnt_o = cap_cnt_q;
endmodule

// File: rtl/cfg_table_walker.sv
module cfg_table_walker
    import ctw_pkg::*;
#(
    parameter int unsigned TADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TADDR_W-1:0] base_i,
    output logic               tbl_rd_en_o,
    output logic [TADDR_W-1:0] tbl_rd_addr_o,
    input  logic [63:0]        tbl_rd_data_i,
    output logic               desc_wr_en_o,
    output logic [31:0]        desc_wr_addr_o,
    output logic [31:0]        desc_wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int unsigned CNT_W = HALF_W;

    ctw_state_e         state_q, state_d;
    logic [TADDR_W-1:0] base_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               launch;
    logic               sig_ok, cnt_zero;
    logic [CNT_W-1:0]   hdr_cnt;
    logic               issue;
    logic [CNT_W-1:0]   issued;
    logic [TADDR_W-1:0] entry_addr;
    logic               pend;
    logic [CNT_W-1:0]   cap_cnt;
    logic               last_cap;

    assign launch   = (state_q == ST_IDLE) && start_i;
    assign last_cap = pend && ((cap_cnt + CNT_W'(1)) == cnt_q);

    ctw_hdr_check u_hdr (
        .word_i       (tbl_rd_data_i),
        .sig_ok_o     (sig_ok),
        .count_o      (hdr_cnt),
        .count_zero_o (cnt_zero)
    );

    ctw_rd_seq #(.TADDR_W(TADDR_W), .CNT_W(CNT_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (launch),
        .issue_i      (issue),
        .base_i       (base_q),
        .issued_o     (issued),
        .entry_addr_o (entry_addr),
        .pend_o       (pend)
    );

    ctw_wr_stage #(.CNT_W(CNT_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (launch),
        .cap_i     (pend),
        .entry_i   (tbl_rd_data_i),
        .wr_en_o   (desc_wr_en_o),
        .wr_addr_o (desc_wr_addr_o),
        .wr_data_o (desc_wr_data_o),
        .cap_cnt_o (cap_cnt)
    );

    // state register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch)
                base_q <= base_i;
            if (state_q == ST_CHECK)
                cnt_q <= hdr_cnt;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_HEAD;
            ST_HEAD:   state_d = ST_CHECK;
            ST_CHECK: begin
                if (!sig_ok)       state_d = ST_FAULT;
                else if (cnt_zero) state_d = ST_FINISH;
                else               state_d = ST_STREAM;
            end
            ST_STREAM: if (last_cap) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue = 1'b0;
        unique case (state_q)
            ST_CHECK:  issue = sig_ok && !cnt_zero;
            ST_STREAM: issue = (issued != cnt_q);
            default:   issue = 1'b0;
        endcase
        tbl_rd_en_o   = (state_q == ST_HEAD) || issue;
        tbl_rd_addr_o = (state_q == ST_HEAD) ? base_q : entry_addr;
        busy_o        = (state_q != ST_IDLE);
        done_o        = (state_q == ST_FINISH);
        err_o         = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/ctw_checker.sv
module ctw_checker #(
    parameter int unsigned TADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               tbl_rd_en_o,
    input logic [TADDR_W-1:0] tbl_rd_addr_o,
    input logic               desc_wr_en_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o
);
    // R7
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !desc_wr_en_o);

    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!desc_wr_en_o && !$past(desc_wr_en_o)));

    // R3
    err_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !desc_wr_en_o);

    // R7
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));

    // R10
    end_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !busy_o);

    // R10
    ports_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en_o || tbl_rd_en_o || done_o || err_o) |-> busy_o);

    // R8
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en_o && $past(tbl_rd_en_o)) |-> (tbl_rd_addr_o == TADDR_W'($past(tbl_rd_addr_o) + 1'b1)));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o && !err_o) |=> busy_o);
endmodule

bind cfg_table_walker ctw_checker #(.TADDR_W(TADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tbl_rd_en_o   (tbl_rd_en_o),
    .tbl_rd_addr_o (tbl_rd_addr_o),
    .desc_wr_en_o  (desc_wr_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/tb_cfg_table_walker.sv
module tb_cfg_table_walker;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [TW-1:0] base_i = '0;
    logic          tbl_rd_en_o;
    logic [TW-1:0] tbl_rd_addr_o;
    logic [63:0]   tbl_rd_data_i = '0;
    logic          desc_wr_en_o;
    logic [31:0]   desc_wr_addr_o, desc_wr_data_o;
    logic          busy_o, done_o, err_o;

    logic [63:0] tmem [0:255];
    logic [31:0] dmem [0:63];
    logic [31:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int nwr, done_edge, err_edge, first_wr, last_wr, ndone, busy_after;
    int nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    cfg_table_walker #(.TADDR_W(TW)) dut (.*);

    always @(posedge clk) begin
        if (tbl_rd_en_o) tbl_rd_data_i <= tmem[tbl_rd_addr_o];
        if (desc_wr_en_o) dmem[desc_wr_addr_o[5:0]] <= desc_wr_data_o;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ent_a(int base, int i);
        return 32'hA000_0000 | 32'((i * 7 + base) % 64);
    endfunction
    function automatic logic [31:0] ent_d(int base, int i);
        return 32'h5A00_0000 + 32'(base * 256 + i);
    endfunction

    task automatic fill(input int base, input int n, input logic [31:0] sig);
        tmem[base % 256] = {sig, 32'(n)};
        for (int i = 0; i < n; i++)
            tmem[(base + 1 + i) % 256] = {ent_a(base, i), ent_d(base, i)};
    endtask

    task automatic walk(input int base, input bit poke);
        int edges = 0, fin = 0;
        nwr = 0; done_edge = -1; err_edge = -1; first_wr = -1; last_wr = -1; ndone = 0; busy_after = -1;
        base_i = TW'(base);
        start_i = 1'b1;
        while (1) begin
            @(negedge clk);
            edges++;
            if (edges == 1) begin
                start_i = 1'b0;
                chk("R10", "busy after start", busy_o, 1);
            end
            if (poke && edges == 2) begin start_i = 1'b1; base_i = TW'(base ^ 8'h55); end
            if (poke && edges == 3) start_i = 1'b0;
            if (desc_wr_en_o) begin
                if (nwr < 64) begin log_a[nwr] = desc_wr_addr_o; log_d[nwr] = desc_wr_data_o; end
                nwr++;
                if (first_wr < 0) first_wr = edges;
                last_wr = edges;
            end
            if (done_o) begin ndone++; if (done_edge < 0) done_edge = edges; if (fin == 0) fin = edges; end
            if (err_o) begin if (err_edge < 0) err_edge = edges; if (fin == 0) fin = edges; end
            if (fin > 0 && edges == fin + 1) busy_after = int'(busy_o);
            if (fin > 0 && edges == fin + 3) break;
            if (edges > 300) begin
                nchk++; nerr++;
                $display("FAIL R7 watchdog actual=hung expected=finish");
                break;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL R7 global watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = '0;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "err", err_o, 0);
        chk("R1", "wr_en", desc_wr_en_o, 0);
        chk("R1", "rd_en", tbl_rd_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of bases and counts, with start pokes on some runs
        for (int b = 0; b < 3; b++) begin
            for (int n = 0; n <= 12; n++) begin
                int base;
                bit poke;
                base = (b == 0) ? 0 : (b == 1) ? 37 : 250;
                poke = (n % 3 == 1);
                fill(base, n, 32'hDEADC0DE);
                walk(base, poke);
                chk("R5", "write count", nwr, n);
                for (int i = 0; i < n && i < 64; i++) begin
                    chk("R4", "entry addr", log_a[i], ent_a(base, i));
                    chk("R4", "entry data", log_d[i], ent_d(base, i));
                end
                chk("R2", "no error on good header", err_edge, -1);
                if (n == 0) chk("R6", "zero-count done latency", done_edge, 3);
                else begin
                    chk("R7", "done latency", done_edge, n + 4);
                    chk("R7", "done follows last write", last_wr, done_edge - 1);
                    chk("R8", "writes back to back", last_wr - first_wr + 1, n);
                end
                chk("R10", "idle after done", busy_after, 0);
                if (poke) chk("R9", "single done despite start while busy", ndone, 1);
            end
        end

        // R3: bad signatures
        for (int k = 0; k < 3; k++) begin
            logic [31:0] sig;
            sig = (k == 0) ? 32'hDEADC0DF : (k == 1) ? 32'h0 : 32'h5EADC0DE;
            fill(60 + k, 3, sig);
            walk(60 + k, k == 2);
            chk("R3", "no writes on bad header", nwr, 0);
            chk("R3", "error latency", err_edge, 3);
            chk("R3", "no done on bad header", ndone, 0);
            chk("R10", "idle after error", busy_after, 0);
        end

        // R5: same target hit several times, later wins
        tmem[100] = {32'hDEADC0DE, 32'd5};
        tmem[101] = {32'h0000_0003, 32'h11};
        tmem[102] = {32'h0000_0007, 32'h22};
        tmem[103] = {32'h0000_0003, 32'h33};
        tmem[104] = {32'h0000_0003, 32'h44};
        tmem[105] = {32'h0000_0007, 32'h55};
        walk(100, 1'b0);
        @(negedge clk);
        chk("R5", "dup write count", nwr, 5);
        chk("R5", "later value wins at 3", dmem[3], 32'h44);
        chk("R5", "later value wins at 7", dmem[7], 32'h55);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule